// File: doc/BRIEF.md
# Byte-Command Memory Exerciser

This block takes a stream of command bytes, one per `rx_valid` pulse, from a serial receiver and uses them to drive five small on-chip memories. The five memories are:

- a single-port RAM whose read data comes straight from the array register;
- a single-port RAM with an extra output register;
- a computed ROM;
- a simple dual-port RAM;
- a true dual-port RAM.

A shared address pointer picks where written data lands. Most byte values are not opcodes and are treated as data. A data byte is written into all four RAMs at once.

A dump command reads back the selected memory and hands each byte to a serial transmitter through a valid/ready handshake. The dump waits the correct read latency for each memory type. A collision command makes both ports of each dual-port RAM touch the same address in the same cycle, and returns the data each reading port saw.

A 16-bit debug bus shows the selected memory's address, strobes and read data, so a logic analyzer can watch the memory's timing directly.

Top module: `mem_exerciser`

## Requirements
- R1: After reset the pointer is 0, the selected memory is the unregistered RAM, `tx_valid` is low, and debug bits 9 and 8 are low.
- R2: Bytes 0x02, 0x03, 0x04, 0x05 and 0x06 select, respectively, the unregistered RAM, the registered RAM, the ROM, the simple dual-port RAM and the true dual-port RAM as the dump and debug target.
- R3: Any byte other than 0x02–0x06 and 0x10–0x12 is written to all four RAMs at the pointer. If its bit 7 is 0, the pointer then advances by one, modulo 2^ADDR_W. If bit 7 is 1, the pointer stays.
- R4: Byte 0x10 sets the pointer to 0 and writes nothing.
- R5: Byte 0x11 sends locations 0 to DUMP_LEN-1 of the selected memory, in ascending order, one byte per `tx_valid && tx_ready` cycle. While `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R6: A dump of the registered RAM returns the stored bytes even though its output lags the address by two cycles. The other memories lag by one cycle.
- R7: ROM location a holds (5·a + 3) mod 256.
- R8: Byte 0x12 runs the collision test at the pointer:
  - the simple dual-port RAM writes COLL_A through port A while port B reads the same address;
  - the true dual-port RAM writes COLL_B through port B while port A reads the same address;
  - the block sends the old simple dual-port byte, then the old true dual-port byte;
  - the pointer is unchanged.
- R9: Bytes that arrive while a dump or collision reply is in progress are ignored: the pointer and the memories do not change.
- R10: The debug bus is {address[5:0], write enable, read strobe, read data[7:0]} for the selected memory, in bits [15:10], [9], [8] and [7:0]. When idle, the address field is the pointer. The ROM never shows a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A command byte is present this cycle |
| rx_data | input | 8 | Command byte |
| tx_ready | input | 1 | Transmitter accepts `tx_data` this cycle |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| dbg_bus | output | 16 | Debug view of the selected memory |

## Verification
The bench builds the block with its default parameters: a 6-bit address, 64-entry memories, a dump length equal to the depth, and collision patterns 0xA5 and 0x5A. With these values a single dump covers every location, so any stray write anywhere shows up in the next dump. Sixty-four advancing writes carry the pointer through its wrap back to zero. The small depth also means the random command mix revisits the same addresses often, so writes, collisions and dumps keep overlapping on shared locations.

// File: rtl/mx_pkg.sv
package mx_pkg;

    typedef enum logic [2:0] {
        TGT_UNREG = 3'd0,
        TGT_REG   = 3'd1,
        TGT_ROM   = 3'd2,
        TGT_SDP   = 3'd3,
        TGT_TDP   = 3'd4
    } tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_COLL,
        ST_CAPT,
        ST_SEND
    } st_e;

    localparam logic [7:0] OP_SEL_LO = 8'h02;
    localparam logic [7:0] OP_SEL_HI = 8'h06;
    localparam logic [7:0] OP_HOME   = 8'h10;
    localparam logic [7:0] OP_DUMP   = 8'h11;
    localparam logic [7:0] OP_COLL   = 8'h12;

    localparam int DBG_AW = 6;

    // cycles from address presentation to valid read data
    function automatic logic [1:0] read_lat(tgt_e t);
        return (t == TGT_REG) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [7:0] rom_word(logic [7:0] a);
        return a * 8'd5 + 8'd3;
    endfunction

endpackage

// File: rtl/mx_ram_sp.sv
module mx_ram_sp #(
    parameter int AW      = 6,
    parameter bit OUT_REG = 1'b0
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wd,
    output logic [7:0]    rd
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] arr_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wd;
        if (re) arr_q <= mem[addr];
    end

    generate
        if (OUT_REG) begin : g_outreg
            logic [7:0] out_q;
            always_ff @(posedge clk) out_q <= arr_q;
            assign rd = out_q;
        end else begin : g_direct
            assign rd = arr_q;
        end
    endgenerate

endmodule

// File: rtl/mx_rom.sv
module mx_rom #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd
);
    import mx_pkg::*;

    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (re) rd_q <= rom_word(8'(addr));
    end

    assign rd = rd_q;

endmodule

// File: rtl/mx_ram_sdp.sv
module mx_ram_sdp #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [AW-1:0] addr_a,
    input  logic [7:0]    wd_a,
    input  logic          re_b,
    input  logic [AW-1:0] addr_b,
    output logic [7:0]    rd_b
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    // read-first: a same-address read returns the value before the write
    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= wd_a;
        if (re_b) rd_q <= mem[addr_b];
    end

    assign rd_b = rd_q;

endmodule

// File: rtl/mx_ram_tdp.sv
module mx_ram_tdp #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic          re_a,
    input  logic [AW-1:0] addr_a,
    input  logic [7:0]    wd_a,
    output logic [7:0]    rd_a,
    input  logic          we_b,
    input  logic [AW-1:0] addr_b,
    input  logic [7:0]    wd_b
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= wd_a;
        if (we_b) mem[addr_b] <= wd_b;
        if (re_a) rd_q <= mem[addr_a];
    end

    assign rd_a = rd_q;

endmodule

// File: rtl/mem_exerciser.sv
module mem_exerciser #(
    parameter int         ADDR_W   = 6,
    parameter int         DUMP_LEN = 64,
    parameter logic [7:0] COLL_A   = 8'hA5,
    parameter logic [7:0] COLL_B   = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic [15:0] dbg_bus
);
    import mx_pkg::*;

    localparam int IW = (DUMP_LEN > 1) ? $clog2(DUMP_LEN) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DUMP_LEN - 1);

    typedef struct packed {
        st_e             st;
        tgt_e            tgt;
        logic [ADDR_W-1:0] ptr;
        logic [IW-1:0]   idx;
        logic [1:0]      cnt;
        logic [7:0]      txd;
        logic [7:0]      hold;
        logic            pend;
        logic            dump;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic              accept_d, is_sel_d, is_data_d, wr_en_d, rd_en_d, coll_d;
    logic [ADDR_W-1:0] mem_addr_d;
    logic [7:0]        un_rd, rg_rd, rom_rd, sdp_rd, tdp_rd;
    logic              sdp_re_b, tdp_re_a;
    logic [7:0]        sel_rd_d;
    logic              sel_we_d, sel_re_d;

    // ---------------- decode ----------------
    always_comb begin
        accept_d  = rx_valid && (cur_q.st == ST_IDLE);
        is_sel_d  = (rx_data >= OP_SEL_LO) && (rx_data <= OP_SEL_HI);
        is_data_d = !(is_sel_d || rx_data == OP_HOME || rx_data == OP_DUMP
                      || rx_data == OP_COLL);
        wr_en_d   = accept_d && is_data_d;
        rd_en_d   = (cur_q.st == ST_READ);
        coll_d    = (cur_q.st == ST_COLL);
        mem_addr_d = rd_en_d ? ADDR_W'(cur_q.idx) : cur_q.ptr;
    end

    // ---------------- memories ----------------
    mx_ram_sp #(.AW(ADDR_W), .OUT_REG(1'b0)) u_unreg (
        .clk(clk), .we(wr_en_d), .re(rd_en_d && cur_q.tgt == TGT_UNREG),
        .addr(mem_addr_d), .wd(rx_data), .rd(un_rd)
    );

    mx_ram_sp #(.AW(ADDR_W), .OUT_REG(1'b1)) u_reg (
        .clk(clk), .we(wr_en_d), .re(rd_en_d && cur_q.tgt == TGT_REG),
        .addr(mem_addr_d), .wd(rx_data), .rd(rg_rd)
    );

    mx_rom #(.AW(ADDR_W)) u_rom (
        .clk(clk), .re(rd_en_d && cur_q.tgt == TGT_ROM),
        .addr(mem_addr_d), .rd(rom_rd)
    );

    assign sdp_re_b = coll_d || (rd_en_d && cur_q.tgt == TGT_SDP);
    assign tdp_re_a = coll_d || (rd_en_d && cur_q.tgt == TGT_TDP);

    mx_ram_sdp #(.AW(ADDR_W)) u_sdp (
        .clk(clk), .we_a(wr_en_d || coll_d), .addr_a(mem_addr_d),
        .wd_a(coll_d ? COLL_A : rx_data),
        .re_b(sdp_re_b), .addr_b(mem_addr_d), .rd_b(sdp_rd)
    );

    mx_ram_tdp #(.AW(ADDR_W)) u_tdp (
        .clk(clk), .we_a(wr_en_d), .re_a(tdp_re_a), .addr_a(mem_addr_d),
        .wd_a(rx_data), .rd_a(tdp_rd),
        .we_b(coll_d), .addr_b(cur_q.ptr), .wd_b(COLL_B)
    );

    // ---------------- target multiplexer ----------------
    always_comb begin
        sel_rd_d = un_rd;
        sel_we_d = wr_en_d;
        sel_re_d = rd_en_d;
        case (cur_q.tgt)
            TGT_REG: sel_rd_d = rg_rd;
            TGT_ROM: begin
                sel_rd_d = rom_rd;
                sel_we_d = 1'b0;
            end
            TGT_SDP: begin
                sel_rd_d = sdp_rd;
                sel_we_d = wr_en_d || coll_d;
                sel_re_d = sdp_re_b;
            end
            TGT_TDP: begin
                sel_rd_d = tdp_rd;
                sel_we_d = wr_en_d || coll_d;
                sel_re_d = tdp_re_a;
            end
            default: ;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (accept_d) begin
                    if (is_sel_d) begin
                        nxt_d.tgt = tgt_e'(rx_data[2:0] - 3'd2);
                    end else if (rx_data == OP_HOME) begin
                        nxt_d.ptr = '0;
                    end else if (rx_data == OP_DUMP) begin
                        nxt_d.st   = ST_READ;
                        nxt_d.idx  = '0;
                        nxt_d.cnt  = '0;
                        nxt_d.dump = 1'b1;
                    end else if (rx_data == OP_COLL) begin
                        nxt_d.st   = ST_COLL;
                        nxt_d.dump = 1'b0;
                    end else if (!rx_data[7]) begin
                        nxt_d.ptr = cur_q.ptr + ADDR_W'(1);
                    end
                end
            end
            ST_READ: begin
                if (cur_q.cnt == read_lat(cur_q.tgt)) begin
                    nxt_d.txd = sel_rd_d;
                    nxt_d.cnt = '0;
                    nxt_d.st  = ST_SEND;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 2'd1;
                end
            end
            ST_COLL: nxt_d.st = ST_CAPT;
            ST_CAPT: begin
                nxt_d.txd  = sdp_rd;
                nxt_d.hold = tdp_rd;
                nxt_d.pend = 1'b1;
                nxt_d.st   = ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (cur_q.dump) begin
                        if (cur_q.idx == LAST_IDX) begin
                            nxt_d.st   = ST_IDLE;
                            nxt_d.dump = 1'b0;
                        end else begin
                            nxt_d.idx = cur_q.idx + IW'(1);
                            nxt_d.st  = ST_READ;
                        end
                    end else if (cur_q.pend) begin
                        nxt_d.txd  = cur_q.hold;
                        nxt_d.pend = 1'b0;
                    end else begin
                        nxt_d.st = ST_IDLE;
                    end
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tx_valid = (cur_q.st == ST_SEND);
    assign tx_data  = cur_q.txd;
    assign dbg_bus  = {DBG_AW'(mem_addr_d), sel_we_d, sel_re_d, sel_rd_d};

    // ---------------- assertions ----------------
    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R5

    AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st != ST_IDLE) |=> $stable(cur_q.ptr)); // R9

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_d && is_data_d && !rx_data[7])
        |=> (cur_q.ptr == $past(cur_q.ptr) + ADDR_W'(1))); // R3

    AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_d && rx_data == OP_HOME) |=> (cur_q.ptr == '0)); // R4

    AST_COLL_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_d && rx_data == OP_COLL) |=> (!tx_valid && dbg_bus[15:10] == DBG_AW'(cur_q.ptr))); // R8

endmodule

// File: tb/mem_exerciser_bench.sv
`timescale 1ns/1ps
module mem_exerciser_bench;

    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam int DUMP_LEN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic [15:0] dbg_bus;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done = 1'b0;

    // bench model
    logic [7:0] m_ram [DEPTH];
    logic [7:0] m_sdp [DEPTH];
    logic [7:0] m_tdp [DEPTH];
    int         ptr_m = 0;
    int         tgt_m = 0;

    mem_exerciser #(.ADDR_W(AW), .DUMP_LEN(DUMP_LEN)) u_mem_exerciser (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .dbg_bus(dbg_bus)
    );

    always #10 clk = ~clk;

    function automatic bit is_op(logic [7:0] b);
        return (b >= 8'h02 && b <= 8'h06) || (b >= 8'h10 && b <= 8'h12);
    endfunction

    function automatic logic [7:0] rom_exp(int a);
        return 8'((a * 5 + 3) % 256);
    endfunction

    function automatic logic [7:0] exp_rd(int t, int a);
        case (t)
            2: return rom_exp(a);
            3: return m_sdp[a];
            4: return m_tdp[a];
            default: return m_ram[a];
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rand_data();
        logic [7:0] b;
        b = 8'($urandom);
        while (is_op(b)) b = 8'($urandom);
        return b;
    endfunction

    // drive one byte, check write-side debug view, update the model
    task automatic send_cmd(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        #1;
        check(dbg_bus[9] == (!is_op(b) && tgt_m != 2), "R10 write enable", dbg_bus[9], 0);
        check(dbg_bus[15:10] == 6'(ptr_m), "R10 address field", dbg_bus[15:10], ptr_m);
        @(negedge clk);
        rx_valid = 1'b0;
        if (b >= 8'h02 && b <= 8'h06) tgt_m = int'(b) - 2;
        else if (b == 8'h10) ptr_m = 0;
        else if (!is_op(b)) begin
            m_ram[ptr_m] = b;
            m_sdp[ptr_m] = b;
            m_tdp[ptr_m] = b;
            if (!b[7]) ptr_m = (ptr_m + 1) % DEPTH;
        end
    endtask

    task automatic raw_byte(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b, input bit dchk);
        bit pv;
        bit got;
        logic [7:0] pd;
        pv = 1'b0;
        got = 1'b0;
        b = 8'h00;
        while (!got) begin
            @(negedge clk);
            if (pv) check(tx_valid && tx_data == pd, "R5 held byte", tx_data, pd);
            tx_ready = ($urandom % 3) != 0;
            #1;
            if (tx_valid && dchk)
                check(dbg_bus[7:0] == tx_data, "R10 read data field", dbg_bus[7:0], tx_data);
            if (tx_valid && tx_ready) begin
                b = tx_data;
                got = 1'b1;
            end
            pv = tx_valid && !tx_ready;
            pd = tx_data;
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic do_dump();
        logic [7:0] b;
        string tag;
        case (tgt_m)
            1: tag = "R2 R6 registered dump";
            2: tag = "R2 R7 rom dump";
            default: tag = "R2 R5 dump";
        endcase
        send_cmd(8'h11);
        for (int i = 0; i < DUMP_LEN; i++) begin
            recv(b, 1'b1);
            check(b == exp_rd(tgt_m, i), tag, b, exp_rd(tgt_m, i));
        end
    endtask

    task automatic do_coll();
        logic [7:0] a, c;
        send_cmd(8'h12);
        recv(a, 1'b0);
        recv(c, 1'b0);
        check(a == m_sdp[ptr_m], "R8 simple dual-port old", a, m_sdp[ptr_m]);
        check(c == m_tdp[ptr_m], "R8 true dual-port old", c, m_tdp[ptr_m]);
        m_sdp[ptr_m] = 8'hA5;
        m_tdp[ptr_m] = 8'h5A;
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        #1;
        check(dbg_bus[15:10] == 6'(ptr_m), tag, dbg_bus[15:10], ptr_m);
        check(dbg_bus[9:8] == 2'b00, "R10 idle strobes", dbg_bus[9:8], 0);
    endtask

    initial begin
        logic [7:0] b;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
        check(dbg_bus[15:10] == 6'd0, "R1 pointer", dbg_bus[15:10], 0);
        check(dbg_bus[9:8] == 2'b00, "R1 strobes", dbg_bus[9:8], 0);

        // fill every location; pointer wraps to 0 (R3)
        for (int i = 0; i < DEPTH; i++) begin
            b = rand_data();
            b[7] = 1'b0;
            while (is_op(b)) begin
                b = rand_data();
                b[7] = 1'b0;
            end
            send_cmd(b);
        end
        idle_check("R3 pointer wrap");
        do_dump();                         // default target is unregistered RAM (R1)

        send_cmd(8'h07);
        idle_check("R3 advance");
        send_cmd(8'h85);
        idle_check("R3 hold on bit 7");
        send_cmd(8'h10);
        idle_check("R4 home");

        // each target in turn (R2, R6, R7)
        for (int t = 2; t <= 6; t++) begin
            send_cmd(8'(t));
            do_dump();
        end

        // collision (R8)
        send_cmd(8'h21);
        send_cmd(8'h22);
        do_coll();
        idle_check("R8 pointer kept");
        send_cmd(8'h05);
        do_dump();
        send_cmd(8'h06);
        do_dump();

        // commands during a dump are dropped (R9)
        send_cmd(8'h02);
        send_cmd(8'h31);
        fork
            begin
                raw_byte(8'h11);
                repeat (6) @(negedge clk);
                raw_byte(8'h10);
                repeat (3) @(negedge clk);
                raw_byte(8'h33);
            end
            begin
                logic [7:0] d;
                for (int i = 0; i < DUMP_LEN; i++) begin
                    recv(d, 1'b1);
                    check(d == exp_rd(0, i), "R9 R5 dump while busy", d, exp_rd(0, i));
                end
            end
        join
        idle_check("R9 pointer untouched");
        do_dump();

        // random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3) do_dump();
            else if (r < 7) do_coll();
            else if (r < 15) send_cmd(8'(2 + $urandom % 5));
            else if (r < 18) send_cmd(8'h10);
            else send_cmd(rand_data());
            if (r >= 7) idle_check("R3 R4 pointer track");
        end
        do_dump();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule